// File: doc/BRIEF.md
# Serial DAC Control Register

This block is the digital front end of a serial-input digital-to-analog converter. A host sends a 24-bit frame over a three-wire link: an active-low frame strobe, a serial clock and serial data. The data is sampled on the falling serial-clock edges, MSB first. When the 24th edge arrives, the frame is committed. The low 16 bits form the converter code. Bits 17:16 select the output-stage mode.

The mode drives four one-hot select lines for the analog side:
- amplifier drive,
- a 1k pull-down to ground,
- a 100k pull-down to ground,
- a high-impedance output.

Leaving power-down starts a wake-up counter. The counter holds the ready flag low until the amplifier has settled.

The serial pins are sampled in the system clock domain, and edges are detected there. The serial clock must therefore stay in each level for at least two system clocks. Power-on reset clears the code to zero and selects normal drive.

Top module: `sdac_ctrl`

## Requirements
- R1: After reset, dac_code is 0, amp_en is 1, pd_1k, pd_100k and out_hiz are 0, and ready is 1.
- R2: Frame bits are shifted MSB first on falling sclk edges while sync_n is low. On the 24th edge, with frame bits 17:16 equal to 00, bits 15:0 appear on dac_code.
- R3: Frame bits 17:16 select the output stage: 00 sets amp_en, 01 sets pd_1k, 10 sets pd_100k, 11 sets out_hiz. Exactly one of these four outputs is high at any time.
- R4: A frame whose bits 17:16 are non-zero changes only the mode; dac_code keeps its stored value.
- R5: If sync_n rises before 24 falling edges, neither dac_code nor the mode changes.
- R6: Frame bits 23:18 have no effect. Falling edges after the 24th in the same frame are ignored.
- R7: ready is 0 in every power-down mode. A frame with bits 17:16 = 00 that leaves a power-down mode holds ready at 0 for WAKE_CYCLES clocks after the commit edge.
- R8: The bit counter returns to zero whenever sync_n is high, so a complete frame after an aborted one loads correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| sync_n | input | 1 | Active-low frame strobe |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | 16 | Stored converter code |
| amp_en | output | 1 | Amplifier drives the output |
| pd_1k | output | 1 | Output tied to ground through 1k |
| pd_100k | output | 1 | Output tied to ground through 100k |
| out_hiz | output | 1 | Output left open |
| ready | output | 1 | Normal mode and wake-up interval elapsed |

## Verification
A wrong bit count or a wrong shift direction shows up on dac_code at the first commit, one clock after the 24th falling edge is seen. A corrupted mode field shows up on the select lines in that same cycle. A wake counter that loads the wrong value, or fails to load, moves the rising edge of ready by a measurable number of clocks. The bench catches this on the clock where it differs. Aborted frames and power-down frames leave their mark only as a lack of change, so dac_code is compared on every cycle after them.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    typedef enum logic [1:0] {
        MODE_RUN    = 2'b00,
        MODE_PD1K   = 2'b01,
        MODE_PD100K = 2'b10,
        MODE_HIZ    = 2'b11
    } pd_mode_e;

    localparam int FRAME_W = 24;
    localparam int CODE_W  = 16;
    localparam int MODE_LO = 16;
endpackage

// File: rtl/sdac_rx.sv
module sdac_rx #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_n,
    input  logic               sclk,
    input  logic               sdin,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    typedef struct packed {
        logic               sclk_q;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sr;
    } rx_t;

    rx_t rx_d, rx_q;
    logic fall;

    always_comb begin
        rx_d      = rx_q;
        frame_vld = 1'b0;
        frame     = {rx_q.sr[FRAME_W-2:0], sdin};
        fall      = rx_q.sclk_q & ~sclk;
        rx_d.sclk_q = sclk;
        if (sync_n) begin
            rx_d.cnt = '0;
        end else if (fall && (rx_q.cnt < FULL)) begin
            rx_d.sr  = frame;
            rx_d.cnt = rx_q.cnt + 1'b1;
            if (rx_q.cnt == LAST) frame_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    p_cnt_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.cnt <= FULL);
    p_sync_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n |=> (rx_q.cnt == '0));
endmodule

// File: rtl/sdac_wake.sv
module sdac_wake #(
    parameter int WAKE_CYCLES = 313
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold,
    output logic idle
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOADV = CNT_W'(WAKE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wk_t;

    wk_t wk_d, wk_q;

    always_comb begin
        wk_d = wk_q;
        if (hold)                wk_d.cnt = '0;
        else if (start)          wk_d.cnt = LOADV;
        else if (wk_q.cnt != '0) wk_d.cnt = wk_q.cnt - 1'b1;
        idle = (wk_q.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

    p_wake_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !hold) |=> (wk_q.cnt == LOADV));
endmodule

// File: rtl/sdac_outsel.sv
module sdac_outsel
    import sdac_pkg::*;
(
    input  pd_mode_e mode,
    output logic     amp_en,
    output logic     pd_1k,
    output logic     pd_100k,
    output logic     out_hiz
);
    always_comb begin
        amp_en  = 1'b0;
        pd_1k   = 1'b0;
        pd_100k = 1'b0;
        out_hiz = 1'b0;
        case (mode)
            MODE_RUN:    amp_en  = 1'b1;
            MODE_PD1K:   pd_1k   = 1'b1;
            MODE_PD100K: pd_100k = 1'b1;
            default:     out_hiz = 1'b1;
        endcase
    end
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
    import sdac_pkg::*;
#(
    parameter int WAKE_CYCLES = 313
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic [CODE_W-1:0] dac_code,
    output logic              amp_en,
    output logic              pd_1k,
    output logic              pd_100k,
    output logic              out_hiz,
    output logic              ready
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        pd_mode_e          mode;
    } reg_t;

    reg_t r_d, r_q;
    logic               frame_vld;
    logic [FRAME_W-1:0] frame;
    pd_mode_e           new_mode;
    logic               wake_start;
    logic               wake_idle;

    sdac_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
        .frame_vld(frame_vld), .frame(frame)
    );

    always_comb begin
        r_d        = r_q;
        new_mode   = pd_mode_e'(frame[MODE_LO+1:MODE_LO]);
        wake_start = 1'b0;
        if (frame_vld) begin
            r_d.mode = new_mode;
            if (new_mode == MODE_RUN) begin
                r_d.code   = frame[CODE_W-1:0];
                wake_start = (r_q.mode != MODE_RUN);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{code: '0, mode: MODE_RUN};
        else        r_q <= r_d;
    end

    sdac_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk(clk), .rst_n(rst_n), .start(wake_start),
        .hold(r_d.mode != MODE_RUN), .idle(wake_idle)
    );

    sdac_outsel u_sel (
        .mode(r_q.mode), .amp_en(amp_en), .pd_1k(pd_1k),
        .pd_100k(pd_100k), .out_hiz(out_hiz)
    );

    assign dac_code = r_q.code;
    assign ready    = (r_q.mode == MODE_RUN) && wake_idle;

    p_code_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_vld && new_mode == MODE_RUN) |=> $stable(dac_code));
    p_ready_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode != MODE_RUN) |-> !ready);
    p_one_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({amp_en, pd_1k, pd_100k, out_hiz}));
    p_wake_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_start |=> !ready);
endmodule

// File: tb/sdac_ctrl_tb.sv
module sdac_ctrl_tb_top;
    localparam int WAKE = 313;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
    logic [15:0] dac_code;
    logic amp_en, pd_1k, pd_100k, out_hiz, ready;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sdac_ctrl #(.WAKE_CYCLES(WAKE)) dut_i (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
        .dac_code(dac_code), .amp_en(amp_en), .pd_1k(pd_1k),
        .pd_100k(pd_100k), .out_hiz(out_hiz), .ready(ready)
    );

    // behavioural reference model
    bit   q[$];
    bit   m_prev = 0;
    int   m_code = 0, m_mode = 0, m_wake = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_prev = 0; m_code = 0; m_mode = 0; m_wake = 0;
        end else begin
            bit start;
            start = 0;
            if (sync_n) q.delete();
            else if (m_prev && !sclk && q.size() < 24) begin
                q.push_back(sdin);
                if (q.size() == 24) begin
                    int fr, nm;
                    fr = 0;
                    foreach (q[k]) fr = (fr << 1) | int'(q[k]);
                    nm = (fr >> 16) & 3;
                    if (nm == 0) begin
                        m_code = fr & 16'hFFFF;
                        start = (m_mode != 0);
                    end
                    m_mode = nm;
                end
            end
            m_prev = sclk;
            if (m_mode != 0) m_wake = 0;
            else if (start) m_wake = WAKE;
            else if (m_wake > 0) m_wake--;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 code", int'(dac_code), m_code);
            chk("R3 select", int'({out_hiz, pd_100k, pd_1k, amp_en}), 1 << m_mode);
            chk("R7 ready", int'(ready), (m_mode == 0 && m_wake == 0) ? 1 : 0);
        end
    end

    task automatic clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [23:0] f, int n);
        sync_n = 1'b0; clks(2);
        for (int i = 0; i < n; i++) begin
            sdin = (i < 24) ? f[23-i] : 1'b1;
            sclk = 1'b1; clks(2);
            sclk = 1'b0; clks(2);
        end
        clks(1);
        sync_n = 1'b1; clks(3);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        clks(3);
        rst_n = 1'b1;
        clks(1);
        // R1 reset state
        chk("R1 code", int'(dac_code), 0);
        chk("R1 amp_en", int'(amp_en), 1);
        chk("R1 ready", int'(ready), 1);
        // R2 plain load
        send(24'h00ABCD, 24);
        chk("R2 load", int'(dac_code), 16'hABCD);
        // R6 high bits ignored, extra edges ignored
        send(24'hFC1234, 26);
        chk("R6 ignore", int'(dac_code), 16'h1234);
        chk("R6 mode", int'(amp_en), 1);
        // R5 abort, then R8 recovery
        send(24'h035555, 10);
        chk("R5 abort code", int'(dac_code), 16'h1234);
        chk("R5 abort mode", int'(amp_en), 1);
        send(24'h00C3A5, 24);
        chk("R8 after abort", int'(dac_code), 16'hC3A5);
        // R3/R4 power-down modes keep code
        send(24'h01FFFF, 24);
        chk("R3 1k", int'(pd_1k), 1);
        chk("R4 keep", int'(dac_code), 16'hC3A5);
        chk("R7 pd ready", int'(ready), 0);
        send(24'h02FFFF, 24);
        chk("R3 100k", int'(pd_100k), 1);
        send(24'h030000, 24);
        chk("R3 hiz", int'(out_hiz), 1);
        chk("R4 keep hiz", int'(dac_code), 16'hC3A5);
        // R7 wake-up
        send(24'h008001, 24);
        chk("R7 waking", int'(ready), 0);
        chk("R2 wake code", int'(dac_code), 16'h8001);
        clks(WAKE + 10);
        chk("R7 awake", int'(ready), 1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule